// File: doc/BRIEF.md
# Key-Guarded Control Register Bank

This block holds a small set of control registers that software may change only through a fixed three-write handshake on a plain memory-mapped port. For each register, the bus first writes a 32-bit opening key to one address, then writes the new value to the register address, then writes a 32-bit closing key to a third address. The value from the middle write waits in a shadow flop. It moves into the live register only when the closing key matches. If any step is wrong or arrives out of turn, the handshake is dropped and the shadow value is lost.

Each register has its own address window of four words, selected by the upper address bits. Offset 0 is the opening key, offset 1 is the register, offset 2 is the closing key, and offset 3 is spare. Each register carries its own key pair, so one register cannot be unlocked with the keys of another. The default build has two registers. Register 0 uses opening key 0x000000AA and closing key 0x00000055. Register 1 uses opening key 0x00000001 and closing key 0x000000F4. The live values come out on a flat output bus, and a one-cycle pulse per register marks each new value taking effect.

Top module: `guarded_ctrl_regs`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every register holds its parameter reset value, every `commit` bit is 0 and `rdata` is 0. With the default parameters, register 0 resets to 0x3C and register 1 to 0xA5.
- R2: Register n takes the new value when three writes arrive in order in window n: the opening key to word address 4n+0, then the value to 4n+1, then the closing key to 4n+2. The new value appears on `reg_q[n*REG_W +: REG_W]` in the cycle after the edge that captures the closing-key write.
- R3: `commit[n]` is high for exactly that one cycle. `reg_q` slice n does not change in any cycle where `commit[n]` is low.
- R4: An opening-key write whose full 32-bit data differs from register n's opening key does not arm the handshake. A value write and a correct closing key that follow it leave the register unchanged.
- R5: A value write with no armed handshake before it is ignored, even if a correct closing key follows.
- R6: A closing-key write with the wrong 32-bit data drops the handshake and the shadow value. A correct closing key sent afterwards commits nothing.
- R7: Any other write inside window n while a handshake is open drops it. This covers a second opening key, a closing key before the value, and a write to the spare offset 3.
- R8: Writes outside window n, including writes to another register's window or to unmapped addresses, do not disturb the handshake of register n.
- R9: A read returns its result on `rdata` one cycle after `addr` is presented. Offset 1 of a window returns the live value, zero-extended. Offsets 0, 2 and 3, and addresses outside every window, return 0.
- R10: Each register checks only its own key pair. The opening and closing keys of register 1 do not unlock register 0.
- R11: Only the low `REG_W` bits of the value write are stored. Higher data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address and data |
| addr | input | ADDR_W | Word address for both writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| reg_q | output | NUM_REG*REG_W | Live register values, register n at bits n*REG_W upward |
| commit | output | NUM_REG | One-cycle pulse per register when a new value takes effect |

## Verification
The bench uses the default build: two registers, 8-bit values and a 4-bit word address. The two windows fill addresses 0 to 7, and 8 to 15 are unmapped. With registers this narrow, the bench can commit every one of the 256 values into both registers. It can also try every opening-key value whose upper 24 bits are zero against each register and confirm that only the right one arms the handshake. The bench then runs each way a handshake can be broken (wrong key, missing step, extra step, spare offset), interleaves the two windows, and reads back every address.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HELD  = 2'd2
  } seq_state_t;

  localparam int KEY_W    = 32;
  localparam int OFF_W    = 2;
  localparam logic [OFF_W-1:0] OFF_OPEN  = 2'd0;
  localparam logic [OFF_W-1:0] OFF_VALUE = 2'd1;
  localparam logic [OFF_W-1:0] OFF_CLOSE = 2'd2;

endpackage

// File: rtl/guard_decode.sv
module guard_decode
  import guard_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_REG = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REG-1:0] win_wr,
  output logic [NUM_REG-1:0] open_wr,
  output logic [NUM_REG-1:0] value_wr,
  output logic [NUM_REG-1:0] close_wr
);

  localparam int SEL_W = ADDR_W - OFF_W;

  logic [SEL_W-1:0] sel;
  logic [OFF_W-1:0] off;

  assign sel = addr[ADDR_W-1:OFF_W];
  assign off = addr[OFF_W-1:0];

  for (genvar n = 0; n < NUM_REG; n++) begin : g_win
    logic hit;
    assign hit         = wr_en && (sel == SEL_W'(n));
    assign win_wr[n]   = hit;
    assign open_wr[n]  = hit && (off == OFF_OPEN);
    assign value_wr[n] = hit && (off == OFF_VALUE);
    assign close_wr[n] = hit && (off == OFF_CLOSE);
  end

endmodule

// File: rtl/guard_seq.sv
module guard_seq
  import guard_pkg::*;
#(
  parameter int                REG_W     = 8,
  parameter logic [KEY_W-1:0]  OPEN_KEY  = 32'h0,
  parameter logic [KEY_W-1:0]  CLOSE_KEY = 32'h0,
  parameter logic [REG_W-1:0]  RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_wr,
  input  logic             open_wr,
  input  logic             value_wr,
  input  logic             close_wr,
  input  logic [KEY_W-1:0] wdata,
  output logic [REG_W-1:0] live,
  output logic             commit
);

  seq_state_t       state;
  logic [REG_W-1:0] shadow;
  logic             open_ok;
  logic             close_ok;

  assign open_ok  = open_wr  && (wdata == OPEN_KEY);
  assign close_ok = close_wr && (wdata == CLOSE_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shadow <= '0;
      live   <= RESET_VAL;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (win_wr) begin
        unique case (state)
          ST_IDLE: begin
            state <= open_ok ? ST_ARMED : ST_IDLE;
          end
          ST_ARMED: begin
            if (value_wr) begin
              shadow <= wdata[REG_W-1:0];
              state  <= ST_HELD;
            end else begin
              shadow <= '0;
              state  <= ST_IDLE;
            end
          end
          ST_HELD: begin
            if (close_ok) begin
              live   <= shadow;
              commit <= 1'b1;
            end
            shadow <= '0;
            state  <= ST_IDLE;
          end
          default: begin
            shadow <= '0;
            state  <= ST_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/guard_rdmux.sv
module guard_rdmux
  import guard_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_REG = 2,
  parameter int REG_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_REG*REG_W-1:0] live_flat,
  output logic [KEY_W-1:0]         rdata
);

  localparam int SEL_W = ADDR_W - OFF_W;

  logic [KEY_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int n = 0; n < NUM_REG; n++) begin
      if (addr[ADDR_W-1:OFF_W] == SEL_W'(n) && addr[OFF_W-1:0] == OFF_VALUE)
        rd_next = KEY_W'(live_flat[n*REG_W +: REG_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/guarded_ctrl_regs.sv
module guarded_ctrl_regs
  import guard_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_REG = 2,
  parameter int REG_W   = 8,
  parameter logic [NUM_REG*KEY_W-1:0] OPEN_KEYS  = {32'h0000_0001, 32'h0000_00AA},
  parameter logic [NUM_REG*KEY_W-1:0] CLOSE_KEYS = {32'h0000_00F4, 32'h0000_0055},
  parameter logic [NUM_REG*REG_W-1:0] RESET_VALS = {8'hA5, 8'h3C}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [KEY_W-1:0]         wdata,
  output logic [KEY_W-1:0]         rdata,
  output logic [NUM_REG*REG_W-1:0] reg_q,
  output logic [NUM_REG-1:0]       commit
);

  logic [NUM_REG-1:0] win_wr;
  logic [NUM_REG-1:0] open_wr;
  logic [NUM_REG-1:0] value_wr;
  logic [NUM_REG-1:0] close_wr;

  guard_decode #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_decode (
    .wr_en    (wr_en),
    .addr     (addr),
    .win_wr   (win_wr),
    .open_wr  (open_wr),
    .value_wr (value_wr),
    .close_wr (close_wr)
  );

  for (genvar n = 0; n < NUM_REG; n++) begin : g_reg
    guard_seq #(
      .REG_W     (REG_W),
      .OPEN_KEY  (OPEN_KEYS[n*KEY_W +: KEY_W]),
      .CLOSE_KEY (CLOSE_KEYS[n*KEY_W +: KEY_W]),
      .RESET_VAL (RESET_VALS[n*REG_W +: REG_W])
    ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .win_wr   (win_wr[n]),
      .open_wr  (open_wr[n]),
      .value_wr (value_wr[n]),
      .close_wr (close_wr[n]),
      .wdata    (wdata),
      .live     (reg_q[n*REG_W +: REG_W]),
      .commit   (commit[n])
    );
  end

  guard_rdmux #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .REG_W(REG_W)) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .live_flat (reg_q),
    .rdata     (rdata)
  );

endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int ADDR_W  = 4,
  parameter int NUM_REG = 2,
  parameter int REG_W   = 8,
  parameter logic [NUM_REG*32-1:0] CLOSE_KEYS = '0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [31:0]              wdata,
  input logic [31:0]              rdata,
  input logic [NUM_REG*REG_W-1:0] reg_q,
  input logic [NUM_REG-1:0]       commit
);

  for (genvar n = 0; n < NUM_REG; n++) begin : g_chk
    localparam logic [ADDR_W-1:0] CLOSE_ADDR = ADDR_W'(n * 4 + 2);

    p_commit_source_r2: assert property (@(posedge clk) disable iff (rst)
      commit[n] |-> $past(wr_en && addr == CLOSE_ADDR &&
                          wdata == CLOSE_KEYS[n*32 +: 32]))
      else $error("commit without closing key");

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      commit[n] |=> !commit[n])
      else $error("commit longer than one cycle");

    p_hold_value_r3: assert property (@(posedge clk) disable iff (rst)
      !commit[n] |-> $stable(reg_q[n*REG_W +: REG_W]))
      else $error("register changed without commit");
  end

  p_key_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(addr[1:0]) != 2'd1) |-> (rdata == 32'd0))
    else $error("non-value offset read nonzero");

endmodule

bind guarded_ctrl_regs guard_checker #(
  .ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .REG_W(REG_W), .CLOSE_KEYS(CLOSE_KEYS)
) u_guard_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .reg_q(reg_q), .commit(commit)
);

// File: tb/test_guarded_ctrl_regs.sv
module test_guarded_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [15:0] reg_q;
  logic [1:0]  commit;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  expv [2];
  logic [31:0] okey [2];
  logic [31:0] ckey [2];

  always #2.5 clk = ~clk;

  guarded_ctrl_regs i_guarded_ctrl_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .reg_q(reg_q), .commit(commit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  function automatic logic [3:0] ad(input int ch, input int off);
    return 4'(ch * 4 + off);
  endfunction

  task automatic check_state(input string req, input logic [1:0] exp_commit);
    check(req, {30'd0, commit}, {30'd0, exp_commit});
    check(req, {16'd0, reg_q}, {16'd0, expv[1], expv[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    expv[0] = 8'h3C; expv[1] = 8'hA5;
    okey[0] = 32'hAA; ckey[0] = 32'h55;
    okey[1] = 32'h01; ckey[1] = 32'hF4;

    repeat (4) @(negedge clk);
    check_state("R1 in reset", 2'b00);
    check("R1 rdata in reset", rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1 after reset", 2'b00);
    check("R1 rdata after reset", rdata, 32'd0);
    rd(ad(1, 1), r);
    check("R1 R9 reset readback", r, 32'hA5);

    // R2 R11: commit every value into both registers, junk in upper bits
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 256; v++) begin
        wr(ad(ch, 0), okey[ch]);
        wr(ad(ch, 1), {24'hA5C3E7 ^ 24'(v * 3), 8'(v)});
        check_state("R2 held until close", 2'b00);
        wr(ad(ch, 2), ckey[ch]);
        expv[ch] = 8'(v);
        check_state("R2 R11 committed", ch == 0 ? 2'b01 : 2'b10);
        @(negedge clk);
        check_state("R3 pulse one cycle", 2'b00);
        if (v % 37 == 0) begin
          rd(ad(ch, 1), r);
          check("R9 value readback", r, {24'd0, expv[ch]});
        end
      end
    end

    // R4: every low-byte opening key except the right one fails to arm
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 256; k++) begin
        if (32'(k) != okey[ch]) begin
          wr(ad(ch, 0), 32'(k));
          wr(ad(ch, 1), 32'h77);
          wr(ad(ch, 2), ckey[ch]);
          check_state("R4 wrong opening key", 2'b00);
        end
      end
      wr(ad(ch, 0), okey[ch] | 32'h0100_0000);
      wr(ad(ch, 1), 32'h66);
      wr(ad(ch, 2), ckey[ch]);
      check_state("R4 upper key bit mismatch", 2'b00);
    end

    // R5: value without opening key
    wr(ad(0, 1), 32'h12);
    wr(ad(0, 2), ckey[0]);
    check_state("R5 unarmed value ignored", 2'b00);

    // R6: wrong closing key drops shadow
    wr(ad(1, 0), okey[1]);
    wr(ad(1, 1), 32'h34);
    wr(ad(1, 2), ckey[1] ^ 32'h1);
    check_state("R6 wrong closing key", 2'b00);
    wr(ad(1, 2), ckey[1]);
    check_state("R6 shadow discarded", 2'b00);

    // R7: out-of-turn writes inside the window
    wr(ad(0, 0), okey[0]);
    wr(ad(0, 0), okey[0]);
    wr(ad(0, 1), 32'h45);
    wr(ad(0, 2), ckey[0]);
    check_state("R7 double opening key", 2'b00);
    wr(ad(0, 0), okey[0]);
    wr(ad(0, 2), ckey[0]);
    wr(ad(0, 1), 32'h46);
    wr(ad(0, 2), ckey[0]);
    check_state("R7 close before value", 2'b00);
    wr(ad(1, 0), okey[1]);
    wr(ad(1, 1), 32'h47);
    wr(ad(1, 3), 32'h0);
    wr(ad(1, 2), ckey[1]);
    check_state("R7 spare offset aborts", 2'b00);

    // R8: interleaved windows and unmapped writes
    wr(ad(0, 0), okey[0]);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(ad(1, 0), okey[1]);
    wr(ad(1, 1), 32'h9E);
    wr(ad(0, 1), 32'h81);
    wr(ad(1, 2), ckey[1]);
    expv[1] = 8'h9E;
    check_state("R8 reg1 commits amid reg0", 2'b10);
    wr(4'hF, 32'h0);
    wr(ad(0, 2), ckey[0]);
    expv[0] = 8'h81;
    check_state("R8 reg0 commits after interleave", 2'b01);

    // R10: register 1 keys on register 0
    wr(ad(0, 0), okey[1]);
    wr(ad(0, 1), 32'h22);
    wr(ad(0, 2), ckey[1]);
    check_state("R10 foreign keys rejected", 2'b00);

    // R9: readback of every address
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      if (a == 1)      check("R9 reg0 read", r, {24'd0, expv[0]});
      else if (a == 5) check("R9 reg1 read", r, {24'd0, expv[1]});
      else             check("R9 zero read", r, 32'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule